// File: doc/BRIEF.md
# Cached-DRAM Page Memory Controller

This block sequences one bank of cached DRAM behind a 32-bit processor local bus. It watches the bus strobe, the read/write line and the page-detect line, and it answers with a ready signal. Towards the memory it drives row and column address selection, the row enable, a merged column-latch/write strobe, a merged write-mode/output-enable, a refresh-mode select and a chip select. It also drives the multiplexed memory address, which is the row part or the column part of the processor address.

Reads that stay inside the row held in the memory's cache finish with no wait state for as long as page-detect stays active. A read to a new row takes one wait state. Writes take two bus cycles and never wait. A short external refresh pulse is latched as a pending request. It is served as soon as the current access has finished, and it always wins over a new access. While the processor is held in reset, the controller runs refresh sequences back to back, which gives the memory its start-up refresh cycles.

Internally the controller runs on a clock at twice the bus rate. A phase bit marks the two halves of each bus cycle. Every output comes straight from a register, so no output is gated by a clock. The state advances only on the edge that ends a bus cycle (the edge where the phase bit is 1).

Top module: `cdram_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first half-cycle after it is released, the controls read idle. In the order ready_n, row_sel_n, col_sel_n, row_en_n, cal_we_n, wrg_n, refsel_n, cs_n this pattern is 1,0,1,1,1,1,1,1. `mem_addr` is 0 during reset, and in idle it carries the row address.
- R2: While `bus_rst_n` is low, the controller repeats refresh (first half), refresh (second half), idle. This gives 8 refresh sequences in 24 bus cycles, whatever the strobe does. In the read-hit state a low `bus_rst_n` returns the machine to idle.
- R3: From idle, an active strobe (`strobe_n`=0) with `rd_wr`=1 (1 = read) starts a read miss, which lasts two bus cycles.
  - In the first cycle, ready_n=1 and row_en_n=0 in both halves. row_sel_n is 0 in the first half and col_sel_n is 0 in the second half. wrg_n=0 and cs_n=0.
  - In the second cycle, ready_n=0, col_sel_n=0, row_en_n=1, wrg_n=0 and cs_n=0.
- R4: In the read-hit state, a read with `page_n`=0 keeps the machine in the read-hit state for the next bus cycle. Ready stays active, so a run of hits has zero wait states.
- R5: In the read-hit state, a read with `page_n`=1 restarts the two-cycle read-miss sequence.
- R6: A write (`strobe_n`=0, `rd_wr`=0) lasts one write bus cycle.
  - Both halves: ready_n=0, row_en_n=0, wrg_n=1 and cs_n=0.
  - First half: row_sel_n=0.
  - Second half: col_sel_n=0 and cal_we_n=0.
  - The next cycle is idle. `page_n` has no effect on the write.
- R7: The cycle after a write is always idle, even when a read is already requested. A read that follows a write therefore starts one bus cycle later.
- R8: A refresh takes two bus cycles, with ready_n=1 and cs_n=1 throughout.
  - First cycle: refsel_n=0 in both halves, with row_en_n=0 in the second half.
  - Second cycle: refsel_n=1, with row_en_n=0 in the first half.
  - The controller then returns to idle.
- R9: A refresh pulse seen during a read miss or a write is held as pending. The refresh starts once that access has finished: straight after the read-hit cycle of the miss, or after the idle cycle that follows the write. The pending flag clears when the refresh ends, so no second refresh follows without a new pulse.
- R10: A pending or present refresh request takes priority over a new strobe, both in idle and in the read-hit state.
- R11: `mem_addr` carries `addr[18:8]` (the row) in every half-cycle where row_sel_n=0. In the other half-cycles of reads and writes it carries `{3'b000, addr[7:0]}` (the column).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| bus_rst_n | input | 1 | Processor reset, active low; forces refresh sequences |
| strobe_n | input | 1 | Bus access strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| page_n | input | 1 | Page-detect, active low: access stays in the cached row |
| refresh_pulse | input | 1 | Short periodic refresh request, active high |
| addr | input | 19 | Processor address, column in the low bits |
| ready_n | output | 1 | Ready to the processor, active low |
| row_sel_n | output | 1 | Row address select, active low |
| col_sel_n | output | 1 | Column address select, active low |
| row_en_n | output | 1 | Memory row enable, active low |
| cal_we_n | output | 1 | Combined column latch / write enable, active low |
| wrg_n | output | 1 | Combined write mode / output enable, low on reads |
| refsel_n | output | 1 | Refresh mode select, active low |
| cs_n | output | 1 | Memory chip select, active low |
| mem_addr | output | 11 | Multiplexed row/column memory address |

## Verification
The bench builds the controller with its default split: an 8-bit column and an 11-bit row. With this split the row field starts at address bit 8. The column is zero-padded up to the 11-bit memory address, so the padding branch of the address multiplexer is exercised. Addresses with distinct row and column fields make a wrong half-cycle selection, or a wrong bit slice, visible on `mem_addr`. Refresh pulses are placed on the exact bus-cycle edges that fall inside a miss, a write and a hit, which brings deferral, preemption and clearing of the pending flag within reach.

// File: rtl/cdram_pkg.sv
package cdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_RD2  = 3'd2,
    ST_WR   = 3'd3,
    ST_RF1  = 3'd4,
    ST_RF2  = 3'd5
  } cd_state_t;

  typedef struct packed {
    logic ready_n;
    logic row_sel_n;
    logic col_sel_n;
    logic row_en_n;
    logic cal_we_n;
    logic wrg_n;
    logic refsel_n;
    logic cs_n;
  } cd_ctl_t;

  localparam cd_ctl_t CTL_RESET = 8'b1011_1111;

  // Control levels for one half of a bus cycle (ph = 1 is the second half)
  function automatic cd_ctl_t cd_decode(input cd_state_t st, input logic ph);
    cd_ctl_t c;
    c = '1;
    case (st)
      ST_IDLE: c.row_sel_n = 1'b0;
      ST_RD1: begin
        c.row_en_n  = 1'b0;
        c.wrg_n     = 1'b0;
        c.cs_n      = 1'b0;
        c.row_sel_n = ph;
        c.col_sel_n = ~ph;
      end
      ST_RD2: begin
        c.ready_n   = 1'b0;
        c.col_sel_n = 1'b0;
        c.wrg_n     = 1'b0;
        c.cs_n      = 1'b0;
      end
      ST_WR: begin
        c.ready_n   = 1'b0;
        c.row_en_n  = 1'b0;
        c.cs_n      = 1'b0;
        c.row_sel_n = ph;
        c.col_sel_n = ~ph;
        c.cal_we_n  = ~ph;
      end
      ST_RF1: begin
        c.refsel_n = 1'b0;
        c.row_en_n = ~ph;
      end
      ST_RF2: c.row_en_n = ph;
      default: c = '1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cdram_seq.sv
module cdram_seq
  import cdram_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_rst_n,
  input  logic      strobe_n,
  input  logic      rd_wr,
  input  logic      page_n,
  input  logic      refresh_pulse,
  output cd_state_t state_q,
  output logic      phase_q,
  output logic      pending_q,
  output cd_state_t nxt_state,
  output logic      nxt_phase
);

  cd_state_t fsm_next;
  logic      refresh_req;
  logic      pending_clear;
  logic      pending_d;
  logic      cycle_end;

  assign cycle_end   = phase_q;
  assign refresh_req = pending_q | refresh_pulse;

  always_comb begin
    fsm_next = state_q;
    case (state_q)
      ST_IDLE: begin
        if (!bus_rst_n || refresh_req) fsm_next = ST_RF1;
        else if (!strobe_n)            fsm_next = rd_wr ? ST_RD1 : ST_WR;
        else                           fsm_next = ST_IDLE;
      end
      ST_RD1: fsm_next = ST_RD2;
      ST_RD2: begin
        if (!bus_rst_n)       fsm_next = ST_IDLE;
        else if (refresh_req) fsm_next = ST_RF1;
        else if (!strobe_n) begin
          if (!rd_wr)        fsm_next = ST_WR;
          else if (!page_n)  fsm_next = ST_RD2;
          else               fsm_next = ST_RD1;
        end
        else                  fsm_next = ST_IDLE;
      end
      ST_WR:   fsm_next = ST_IDLE;
      ST_RF1:  fsm_next = ST_RF2;
      ST_RF2:  fsm_next = ST_IDLE;
      default: fsm_next = ST_IDLE;
    endcase
  end

  always_comb begin
    nxt_phase     = ~phase_q;
    nxt_state     = cycle_end ? fsm_next : state_q;
    pending_clear = cycle_end && (state_q == ST_RF2);
    pending_d     = (pending_q | refresh_pulse) & ~pending_clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      phase_q   <= nxt_phase;
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (cycle_end) begin
      state_q <= fsm_next;
    end
  end

endmodule

// File: rtl/cdram_ctl_gen.sv
module cdram_ctl_gen
  import cdram_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cd_state_t nxt_state,
  input  logic      nxt_phase,
  output cd_ctl_t   ctl_q,
  output logic      use_row_next
);

  cd_ctl_t ctl_next;

  always_comb begin
    ctl_next     = cd_decode(nxt_state, nxt_phase);
    use_row_next = ~ctl_next.row_sel_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_next;
  end

endmodule

// File: rtl/cdram_addr_mux.sv
module cdram_addr_mux #(
  parameter int COL_W = 8,
  parameter int ROW_W = 11,
  localparam int ADDR_W = COL_W + ROW_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              use_row,
  output logic [MA_W-1:0]   mem_addr
);

  logic [MA_W-1:0] row_part;
  logic [MA_W-1:0] col_part;
  logic [MA_W-1:0] addr_next;

  generate
    if (ROW_W >= COL_W) begin : g_pad_col
      assign row_part = addr[ADDR_W-1:COL_W];
      if (ROW_W > COL_W) begin : g_zero
        assign col_part = {{(MA_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      end else begin : g_same
        assign col_part = addr[COL_W-1:0];
      end
    end else begin : g_pad_row
      assign row_part = {{(MA_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
      assign col_part = addr[COL_W-1:0];
    end
  endgenerate

  assign addr_next = use_row ? row_part : col_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_addr <= '0;
    else        mem_addr <= addr_next;
  end

endmodule

// File: rtl/cdram_ctrl.sv
module cdram_ctrl
  import cdram_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int ROW_W = 11,
  localparam int ADDR_W = COL_W + ROW_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_n,
  input  logic              strobe_n,
  input  logic              rd_wr,
  input  logic              page_n,
  input  logic              refresh_pulse,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready_n,
  output logic              row_sel_n,
  output logic              col_sel_n,
  output logic              row_en_n,
  output logic              cal_we_n,
  output logic              wrg_n,
  output logic              refsel_n,
  output logic              cs_n,
  output logic [MA_W-1:0]   mem_addr
);

  cd_state_t state_q;
  cd_state_t nxt_state;
  logic      phase_q;
  logic      nxt_phase;
  logic      pending_q;
  logic      use_row_next;
  cd_ctl_t   ctl_q;

  cdram_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rst_n     (bus_rst_n),
    .strobe_n      (strobe_n),
    .rd_wr         (rd_wr),
    .page_n        (page_n),
    .refresh_pulse (refresh_pulse),
    .state_q       (state_q),
    .phase_q       (phase_q),
    .pending_q     (pending_q),
    .nxt_state     (nxt_state),
    .nxt_phase     (nxt_phase)
  );

  cdram_ctl_gen u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .nxt_state    (nxt_state),
    .nxt_phase    (nxt_phase),
    .ctl_q        (ctl_q),
    .use_row_next (use_row_next)
  );

  cdram_addr_mux #(.COL_W(COL_W), .ROW_W(ROW_W)) u_amux (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .use_row  (use_row_next),
    .mem_addr (mem_addr)
  );

  assign ready_n   = ctl_q.ready_n;
  assign row_sel_n = ctl_q.row_sel_n;
  assign col_sel_n = ctl_q.col_sel_n;
  assign row_en_n  = ctl_q.row_en_n;
  assign cal_we_n  = ctl_q.cal_we_n;
  assign wrg_n     = ctl_q.wrg_n;
  assign refsel_n  = ctl_q.refsel_n;
  assign cs_n      = ctl_q.cs_n;

endmodule

// File: rtl/cdram_chk.sv
module cdram_chk
  import cdram_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      bus_rst_n,
  input logic      strobe_n,
  input logic      rd_wr,
  input logic      page_n,
  input logic      refresh_pulse,
  input logic      ready_n,
  input logic      row_en_n,
  input logic      refsel_n,
  input cd_state_t state_q,
  input logic      phase_q,
  input logic      pending_q
);

  logic quiet_req;
  assign quiet_req = bus_rst_n && !pending_q && !refresh_pulse;

  assert_miss_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && phase_q && quiet_req && !strobe_n && rd_wr)
      |=> (state_q == ST_RD1 && ready_n));

  assert_miss_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD1 && phase_q) |=> (state_q == ST_RD2));

  assert_hit_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD2 && phase_q && quiet_req && !strobe_n && rd_wr && !page_n)
      |=> (state_q == ST_RD2 && !ready_n));

  assert_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && phase_q) |=> (state_q == ST_IDLE));

  assert_ref_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refsel_n) |=> !row_en_n);

  assert_ref_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RF1 || state_q == ST_RF2) |-> ready_n);

  assert_pending_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !(state_q == ST_RF2 && phase_q)) |=> pending_q);

  assert_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD2 && phase_q && bus_rst_n && pending_q) |=> (state_q == ST_RF1));

endmodule

bind cdram_ctrl cdram_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rst_n     (bus_rst_n),
  .strobe_n      (strobe_n),
  .rd_wr         (rd_wr),
  .page_n        (page_n),
  .refresh_pulse (refresh_pulse),
  .ready_n       (ready_n),
  .row_en_n      (row_en_n),
  .refsel_n      (refsel_n),
  .state_q       (state_q),
  .phase_q       (phase_q),
  .pending_q     (pending_q)
);

// File: tb/tb_cdram_ctrl.sv
module tb_cdram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W  = 8;
  localparam int ROW_W  = 11;
  localparam int ADDR_W = COL_W + ROW_W;
  localparam int MA_W   = ROW_W;

  localparam int S_I  = 0;
  localparam int S_R1 = 1;
  localparam int S_R2 = 2;
  localparam int S_W  = 3;
  localparam int S_F1 = 4;
  localparam int S_F2 = 5;

  logic clk = 1'b0;
  logic rst_n, bus_rst_n, strobe_n, rd_wr, page_n, refresh_pulse;
  logic [ADDR_W-1:0] addr;
  logic ready_n, row_sel_n, col_sel_n, row_en_n, cal_we_n, wrg_n, refsel_n, cs_n;
  logic [MA_W-1:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int ref_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdram_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .strobe_n(strobe_n),
    .rd_wr(rd_wr), .page_n(page_n), .refresh_pulse(refresh_pulse), .addr(addr),
    .ready_n(ready_n), .row_sel_n(row_sel_n), .col_sel_n(col_sel_n),
    .row_en_n(row_en_n), .cal_we_n(cal_we_n), .wrg_n(wrg_n),
    .refsel_n(refsel_n), .cs_n(cs_n), .mem_addr(mem_addr)
  );

  // Expected control levels from the requirements,
  // order: ready,row_sel,col_sel,row_en,cal_we,wrg,refsel,cs
  function automatic logic [7:0] expv(input int st, input bit ph);
    case (st)
      S_I:     return 8'b1011_1111;
      S_R1:    return ph ? 8'b1100_1010 : 8'b1010_1010;
      S_R2:    return 8'b0101_1010;
      S_W:     return ph ? 8'b0100_0110 : 8'b0010_1110;
      S_F1:    return ph ? 8'b1110_1101 : 8'b1111_1101;
      S_F2:    return ph ? 8'b1111_1111 : 8'b1110_1111;
      default: return 8'hxx;
    endcase
  endfunction

  function automatic logic [7:0] actv();
    return {ready_n, row_sel_n, col_sel_n, row_en_n, cal_we_n, wrg_n, refsel_n, cs_n};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sample(input int st, input bit ph, input string tag);
    logic [7:0] e;
    logic [MA_W-1:0] ea;
    e = expv(st, ph);
    check(actv() === e, tag, {8'h0, actv()}, {8'h0, e});
    if (!ph && !refsel_n) ref_seen++;
    if (st != S_F1 && st != S_F2) begin
      ea = (e[6] == 1'b0) ? addr[ADDR_W-1:COL_W] : {{(MA_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      check(mem_addr === ea, {tag, " R11 mem_addr"}, {5'h0, mem_addr}, {5'h0, ea});
    end
  endtask

  // One bus cycle: both halves checked; ends at the second-half negedge
  task automatic cyc(input int st, input string tag);
    @(negedge clk);
    refresh_pulse = 1'b0;
    sample(st, 1'b0, tag);
    @(negedge clk);
    sample(st, 1'b1, tag);
  endtask

  task automatic drive(input bit s_n, input bit rw, input bit pg_n, input logic [ADDR_W-1:0] a);
    strobe_n = s_n;
    rd_wr    = rw;
    page_n   = pg_n;
    addr     = a;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(actv() === 8'b1011_1111, "R1 reset controls", {8'h0, actv()}, 16'h00BF);
    check(mem_addr === '0, "R1 reset mem_addr", {5'h0, mem_addr}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    sample(S_I, 1'b1, "R1 first idle half");
  endtask

  task automatic t_miss_hit();
    drive(0, 1, 1, 19'h5A3C7);
    cyc(S_R1, "R3 miss first");
    cyc(S_R2, "R3 miss second");
    drive(0, 1, 0, 19'h5A312);
    cyc(S_R2, "R4 hit one");
    drive(0, 1, 0, 19'h5A3F0);
    cyc(S_R2, "R4 hit two");
    drive(0, 1, 1, 19'h2B4A5);
    cyc(S_R1, "R5 new row first");
    cyc(S_R2, "R5 new row second");
    drive(1, 1, 1, 19'h2B4A5);
    cyc(S_I, "R3 back to idle");
  endtask

  task automatic t_write();
    drive(0, 0, 0, 19'h1F00D);
    cyc(S_W, "R6 write page low");
    drive(0, 1, 1, 19'h36C5A);
    cyc(S_I, "R7 idle after write");
    cyc(S_R1, "R7 read after write");
    cyc(S_R2, "R7 read after write done");
    drive(0, 0, 1, 19'h40B3C);
    cyc(S_W, "R6 write page high");
    drive(1, 1, 1, 19'h40B3C);
    cyc(S_I, "R6 write second cycle idle");
    cyc(S_I, "R6 idle");
  endtask

  task automatic t_refresh_idle();
    drive(0, 1, 1, 19'h12345);
    refresh_pulse = 1'b1;
    cyc(S_F1, "R8 R10 refresh first over strobe");
    cyc(S_F2, "R8 refresh second");
    cyc(S_I, "R8 idle after refresh");
    cyc(S_R1, "R10 read after refresh");
    cyc(S_R2, "R10 read second");
    drive(0, 1, 0, 19'h12399);
    refresh_pulse = 1'b1;
    cyc(S_F1, "R10 refresh preempts hit");
    cyc(S_F2, "R10 refresh second");
    drive(1, 1, 1, 19'h12399);
    cyc(S_I, "R10 idle");
    cyc(S_I, "R10 idle hold");
  endtask

  task automatic t_pending();
    drive(0, 1, 1, 19'h7ABCD);
    cyc(S_R1, "R9 miss first");
    drive(0, 1, 0, 19'h7AB11);
    refresh_pulse = 1'b1;
    cyc(S_R2, "R9 refresh deferred past miss");
    cyc(S_F1, "R9 refresh after miss");
    cyc(S_F2, "R9 refresh second");
    drive(1, 1, 1, 19'h7AB11);
    cyc(S_I, "R9 idle");
    cyc(S_I, "R9 pending cleared");
    drive(0, 0, 1, 19'h0CAFE);
    cyc(S_W, "R9 write");
    drive(1, 1, 1, 19'h0CAFE);
    refresh_pulse = 1'b1;
    cyc(S_I, "R9 write completes first");
    cyc(S_F1, "R9 refresh after write");
    cyc(S_F2, "R9 refresh second after write");
    cyc(S_I, "R9 idle after write refresh");
    cyc(S_I, "R9 cleared after write refresh");
  endtask

  task automatic t_bus_reset();
    bus_rst_n = 1'b0;
    drive(0, 1, 1, 19'h33333);
    ref_seen = 0;
    for (int k = 0; k < 8; k++) begin
      cyc(S_F1, "R2 reset refresh first");
      cyc(S_F2, "R2 reset refresh second");
      cyc(S_I, "R2 reset idle");
    end
    check(ref_seen == 8, "R2 refresh count", 16'(ref_seen), 16'd8);
    bus_rst_n = 1'b1;
    cyc(S_R1, "R2 read after reset");
    bus_rst_n = 1'b0;
    cyc(S_R2, "R2 read second");
    drive(1, 1, 1, 19'h33333);
    cyc(S_I, "R2 hit state to idle on reset");
    cyc(S_F1, "R2 refresh");
    bus_rst_n = 1'b1;
    cyc(S_F2, "R2 refresh second");
    cyc(S_I, "R2 idle after release");
  endtask

  initial begin
    rst_n = 1'b0;
    bus_rst_n = 1'b1;
    refresh_pulse = 1'b0;
    drive(1, 1, 1, 19'h5A3C7);
    t_reset();
    t_miss_hit();
    t_write();
    t_refresh_idle();
    t_pending();
    t_bus_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule